// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital half of a power supervisor. Comparators outside the block report three levels, already synchronous to the block clock: the main supply is above its first trip point, a second monitored rail is above its own trip point, and the supply is high enough (roughly one volt) for any output to mean something. The block also takes a push-button reset input, active low, and a two-bit code that selects how long reset is held after every cause of reset has gone away.

It drives a system reset in both polarities and an active-low warning for the second rail. Reset goes up the moment the main supply is seen below its trip point. It is released only after a run of clean cycles as long as the selected delay, with the main supply good and the button released. A dip or a button press during that run starts the count again from zero. The second-rail warning follows its comparator with no delay of its own, so it can be used either to interrupt a processor ahead of a power failure or to be combined with reset. All pins are plain level signals: there is no data stream and no handshake.

Top module: `supv_reset_seq`

## Requirements
- R1: While `rst_n` is low and just after it rises, `sys_rst_o` is 1, `sys_rst_n_o` is 0 and the release counter starts from zero.
- R2: Reset is released after exactly N consecutive rising clock edges with `core_alive_i`=1, `v1_ok_i`=1 and the button released, where N is 50, 200, 400 or 800 for the latched delay code 2'b00, 2'b01, 2'b10 or 2'b11.
- R3: `sys_rst_o` is 1 in the same cycle that `v1_ok_i` is 0 (no clock edge needed), and stays 1 until a fresh full delay has elapsed.
- R4: `mr_n_i` passes a two-flop synchronizer; the button counts as pressed (or released) only once four consecutive synchronized samples differ from the accepted level, so a low pulse of 3 cycles has no effect on `sys_rst_o` and a pulse of 4 cycles asserts it.
- R5: While the button is recognized as pressed, reset is held; after `mr_n_i` returns high, reset is released N+6 edges later (2 synchronizer edges, 4 debounce edges, then N clean edges).
- R6: With `core_alive_i`=1, `v2_fail_n_o` equals `v2_ok_i` in the same cycle, both falling and rising, with no added delay.
- R7: With `core_alive_i`=0, `sys_rst_o` is 1 and `v2_fail_n_o` is 0 whatever the other inputs, and the release count restarts.
- R8: `sys_rst_n_o` is always the complement of `sys_rst_o`.
- R9: The delay code is sampled only on edges where reset is asserted; changing `dly_sel_i` while reset is released has no effect on `sys_rst_o`, and the code present at the last asserted edge sets N for the next release.
- R10: Any dip of `v1_ok_i` or `core_alive_i` or any recognized press during the count clears it, so the next release needs N full clean edges counted from the end of the dip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that times the delay |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| core_alive_i | input | 1 | Supply above the minimum level for valid outputs |
| v1_ok_i | input | 1 | Main supply above trip level 1 |
| v2_ok_i | input | 1 | Second rail above trip level 2 |
| mr_n_i | input | 1 | Push-button reset, active low, asynchronous |
| dly_sel_i | input | 2 | Release delay code |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| v2_fail_n_o | output | 1 | Second-rail warning, active low |

## Verification
A stuck or miscounted release counter shows only at the moment of release, up to 806 cycles after the last cause of reset, as reset falling early or late by the error; the bench therefore measures whole release windows for each delay code and after dips and button presses placed mid-count. A wrong latched delay code shows as a release window of another length at the next release, not while reset is released. A debounce or synchronizer fault shows within about six cycles of a button edge, as a 3-cycle glitch that asserts reset or a press that never does. The combinational paths for the trip inputs and the second rail are compared in the very cycle an input changes, before any clock edge.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    DLY_SHORT = 2'b00,
    DLY_MED   = 2'b01,
    DLY_LONG  = 2'b10,
    DLY_MAX   = 2'b11
  } dly_code_e;

  // Largest of four tick counts, used to size the release counter.
  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/supv_mr_cond.sv
// Push-button conditioner: synchronizer chain followed by a run-length debounce.
module supv_mr_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DB_LEN      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_i,
  output logic mr_active_o
);
  localparam int unsigned DB_W = (DB_LEN > 1) ? $clog2(DB_LEN) : 1;
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DB_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_q;   // accepted level of mr_n, 1 = released
  logic [DB_W-1:0]        run_q;

  // Synchronizer chain, stage 0 takes the raw pin.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= mr_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  logic sampled;
  assign sampled = sync_q[SYNC_STAGES-1];

  // Accept a new level only after DB_LEN consecutive differing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (sampled != level_q) begin
      if (run_q == DB_LAST) begin
        level_q <= sampled;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign mr_active_o = ~level_q;

endmodule

// File: rtl/supv_rel_timer.sv
// Release timer: holds reset while any cause is present, then counts a
// clean window whose length is chosen by a code latched while in reset.
module supv_rel_timer
  import supv_pkg::*;
#(
  parameter int unsigned TICKS0 = 50,
  parameter int unsigned TICKS1 = 200,
  parameter int unsigned TICKS2 = 400,
  parameter int unsigned TICKS3 = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic [1:0] dly_sel_i,
  output logic       rst_q_o
);
  localparam int unsigned TMAX  = max4(TICKS0, TICKS1, TICKS2, TICKS3);
  localparam int unsigned CNT_W = $clog2(TMAX + 1);

  dly_code_e        code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_tick;
  logic             rst_q;

  always_comb begin
    unique case (code_q)
      DLY_SHORT: last_tick = CNT_W'(TICKS0 - 1);
      DLY_MED:   last_tick = CNT_W'(TICKS1 - 1);
      DLY_LONG:  last_tick = CNT_W'(TICKS2 - 1);
      default:   last_tick = CNT_W'(TICKS3 - 1);
    endcase
  end

  // Delay code follows the pin only while reset is asserted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= DLY_SHORT;
    else if (rst_q) code_q <= dly_code_e'(dly_sel_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (hold_i) begin
      rst_q <= 1'b1;
      cnt_q <= '0;
    end else if (rst_q) begin
      if (cnt_q == last_tick) begin
        rst_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_q_o = rst_q;

endmodule

// File: rtl/supv_out_gate.sv
// Combines causes of reset and forms the output pins.
module supv_out_gate (
  input  logic core_alive_i,
  input  logic v1_ok_i,
  input  logic v2_ok_i,
  input  logic mr_active_i,
  input  logic rst_q_i,
  output logic hold_o,
  output logic sys_rst_o,
  output logic sys_rst_n_o,
  output logic v2_fail_n_o
);
  logic rst_any;

  always_comb begin
    hold_o      = ~core_alive_i | ~v1_ok_i | mr_active_i;
    rst_any     = rst_q_i | hold_o;
    sys_rst_o   = rst_any;
    sys_rst_n_o = ~rst_any;
    v2_fail_n_o = core_alive_i & v2_ok_i;
  end

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
  parameter int unsigned TICKS0      = 50,
  parameter int unsigned TICKS1      = 200,
  parameter int unsigned TICKS2      = 400,
  parameter int unsigned TICKS3      = 800,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DB_LEN      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_alive_i,
  input  logic       v1_ok_i,
  input  logic       v2_ok_i,
  input  logic       mr_n_i,
  input  logic [1:0] dly_sel_i,
  output logic       sys_rst_o,
  output logic       sys_rst_n_o,
  output logic       v2_fail_n_o
);
  logic mr_active;
  logic hold;
  logic rst_q;

  supv_mr_cond #(
    .SYNC_STAGES(SYNC_STAGES),
    .DB_LEN     (DB_LEN)
  ) u_mr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mr_n_i     (mr_n_i),
    .mr_active_o(mr_active)
  );

  supv_rel_timer #(
    .TICKS0(TICKS0),
    .TICKS1(TICKS1),
    .TICKS2(TICKS2),
    .TICKS3(TICKS3)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (hold),
    .dly_sel_i(dly_sel_i),
    .rst_q_o  (rst_q)
  );

  supv_out_gate u_gate (
    .core_alive_i(core_alive_i),
    .v1_ok_i     (v1_ok_i),
    .v2_ok_i     (v2_ok_i),
    .mr_active_i (mr_active),
    .rst_q_i     (rst_q),
    .hold_o      (hold),
    .sys_rst_o   (sys_rst_o),
    .sys_rst_n_o (sys_rst_n_o),
    .v2_fail_n_o (v2_fail_n_o)
  );

endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk #(
  parameter int unsigned TICKS0 = 50
) (
  input logic clk,
  input logic rst_n,
  input logic core_alive_i,
  input logic v1_ok_i,
  input logic v2_ok_i,
  input logic mr_active,
  input logic sys_rst_o,
  input logic sys_rst_n_o,
  input logic v2_fail_n_o
);
  // Count clean cycles spent in reset, saturating, to bound the release window.
  logic [15:0] clean_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clean_cnt <= '0;
    else if (!sys_rst_o || !core_alive_i || !v1_ok_i || mr_active) clean_cnt <= '0;
    else if (clean_cnt != 16'hFFFF) clean_cnt <= clean_cnt + 1'b1;
  end

  p_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o == !sys_rst_n_o);

  p_v1_low_resets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_ok_i |-> sys_rst_o);

  p_v2_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_alive_i |-> (v2_fail_n_o == v2_ok_i));

  p_dead_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !core_alive_i |-> (sys_rst_o && !v2_fail_n_o));

  p_button_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mr_active |-> sys_rst_o);

  p_min_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> ($past(clean_cnt) >= 16'(TICKS0 - 1)));

  p_release_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> ($past(v1_ok_i) && $past(core_alive_i) && !$past(mr_active)));

endmodule

bind supv_reset_seq supv_reset_seq_chk #(.TICKS0(TICKS0)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_alive_i(core_alive_i),
  .v1_ok_i     (v1_ok_i),
  .v2_ok_i     (v2_ok_i),
  .mr_active   (mr_active),
  .sys_rst_o   (sys_rst_o),
  .sys_rst_n_o (sys_rst_n_o),
  .v2_fail_n_o (v2_fail_n_o)
);

// File: tb/supv_reset_seq_test.sv
module supv_reset_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       core_alive_i, v1_ok_i, v2_ok_i, mr_n_i;
  logic [1:0] dly_sel_i;
  logic       sys_rst_o, sys_rst_n_o, v2_fail_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_seq uut (
    .clk(clk), .rst_n(rst_n), .core_alive_i(core_alive_i), .v1_ok_i(v1_ok_i),
    .v2_ok_i(v2_ok_i), .mr_n_i(mr_n_i), .dly_sel_i(dly_sel_i),
    .sys_rst_o(sys_rst_o), .sys_rst_n_o(sys_rst_n_o), .v2_fail_n_o(v2_fail_n_o)
  );

  // Reference state built from the requirements.
  bit m_s1, m_s2, m_lvl, m_rq;
  int m_run, m_cnt, m_code;

  function automatic int ticks_of(input int code);
    case (code)
      0: return 50;
      1: return 200;
      2: return 400;
      default: return 800;
    endcase
  endfunction

  function automatic bit exp_rst();
    return m_rq | !v1_ok_i | !core_alive_i | !m_lvl;
  endfunction

  function automatic bit exp_v2n();
    return v2_ok_i & core_alive_i;
  endfunction

  task automatic model_reset();
    m_s1 = 1; m_s2 = 1; m_lvl = 1; m_rq = 1; m_run = 0; m_cnt = 0; m_code = 0;
  endtask

  task automatic model_edge();
    bit hold, old_rq, old_s2;
    hold   = !v1_ok_i | !core_alive_i | !m_lvl;
    old_rq = m_rq;
    old_s2 = m_s2;
    // R4 debounce on the synchronized sample present before this edge
    if (old_s2 != m_lvl) begin
      if (m_run == 3) begin m_lvl = old_s2; m_run = 0; end
      else m_run++;
    end else m_run = 0;
    m_s2 = m_s1;
    m_s1 = mr_n_i;
    // R2/R10 release window, R9 code latch
    if (hold) begin m_rq = 1; m_cnt = 0; end
    else if (old_rq) begin
      if (m_cnt == ticks_of(m_code) - 1) begin m_rq = 0; m_cnt = 0; end
      else m_cnt++;
    end
    if (old_rq) m_code = int'(dly_sel_i);
  endtask

  task automatic chk(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails <= 30) $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, sys_rst_o, exp_rst());
    chk("R8", sys_rst_n_o, !exp_rst());
    chk(core_alive_i ? "R6" : "R7", v2_fail_n_o, exp_v2n());
  endtask

  // Caller sets inputs just after a falling edge, then calls step.
  task automatic step(input string tag);
    #1 compare(tag);
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
  endtask

  task automatic measure(input string tag, input int limit, output int n);
    n = 0;
    while (sys_rst_o && n < limit) begin step(tag); n++; end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst_n = 0; core_alive_i = 0; v1_ok_i = 0; v2_ok_i = 0; mr_n_i = 1; dly_sel_i = 2'b01;
    model_reset();
    @(negedge clk);
    repeat (3) step("R1");
    chk("R1", sys_rst_o, 1'b1);
    chk("R1", sys_rst_n_o, 1'b0);
    rst_n = 1;
    step("R7");
    chk("R7", v2_fail_n_o, 1'b0);

    // R2 power-up with code 01
    core_alive_i = 1; v1_ok_i = 1; v2_ok_i = 1;
    measure("R2", 2000, n);
    chk("R2", n == 200, 1'b1);

    // R9 code changes while released are ignored
    for (int i = 0; i < 300; i++) begin
      dly_sel_i = (i < 150) ? 2'b11 : 2'b00;
      step("R9");
    end
    chk("R9", sys_rst_o, 1'b0);

    // R3 one-cycle dip asserts at once, then window of code 00 (50)
    v1_ok_i = 0;
    #1 chk("R3", sys_rst_o, 1'b1);
    step("R3");
    v1_ok_i = 1;
    measure("R3", 2000, n);
    chk("R3", n == 50, 1'b1);

    // R10 dip mid-count restarts
    dly_sel_i = 2'b10;
    v1_ok_i = 0; step("R10"); v1_ok_i = 1;
    repeat (100) step("R10");
    v1_ok_i = 0; step("R10"); v1_ok_i = 1;
    measure("R10", 2000, n);
    chk("R10", n == 400, 1'b1);

    // R4 3-cycle glitch ignored
    dly_sel_i = 2'b00;
    mr_n_i = 0; repeat (3) step("R4"); mr_n_i = 1;
    repeat (12) step("R4");
    chk("R4", sys_rst_o, 1'b0);
    // R4 4-cycle pulse accepted
    mr_n_i = 0; repeat (4) step("R4"); mr_n_i = 1;
    repeat (4) step("R4");
    chk("R4", sys_rst_o, 1'b1);
    measure("R4", 2000, n);

    // R5 long press then N+6
    dly_sel_i = 2'b10;
    mr_n_i = 0; repeat (100) step("R5");
    chk("R5", sys_rst_o, 1'b1);
    mr_n_i = 1;
    measure("R5", 2000, n);
    chk("R5", n == 406, 1'b1);

    // R6 second rail follows in the same cycle
    v2_ok_i = 0; #1 chk("R6", v2_fail_n_o, 1'b0); step("R6");
    v2_ok_i = 1; #1 chk("R6", v2_fail_n_o, 1'b1); step("R6");

    // R7 core dead forces both outputs
    core_alive_i = 0; #1 chk("R7", sys_rst_o, 1'b1); chk("R7", v2_fail_n_o, 1'b0);
    repeat (5) step("R7");
    core_alive_i = 1;
    dly_sel_i = 2'b11;
    measure("R7", 2000, n);
    chk("R7", n == 800, 1'b1);

    // Random mix
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(199) == 0) v1_ok_i = ~v1_ok_i;
      if ($urandom_range(19) == 0)  v2_ok_i = ~v2_ok_i;
      if ($urandom_range(99) == 0)  mr_n_i = ~mr_n_i;
      if ($urandom_range(999) == 0) core_alive_i = ~core_alive_i;
      if ($urandom_range(49) == 0)  dly_sel_i = 2'($urandom_range(3));
      if (!v1_ok_i && $urandom_range(3) == 0) v1_ok_i = 1;
      if (!core_alive_i && $urandom_range(7) == 0) core_alive_i = 1;
      step("R2");
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule